// File: doc/BRIEF.md
# Two-Stage Time-Space Switching Fabric

The block is a circuit-switched fabric for 8-bit samples. It is built from a rectangular grid of identical switch nodes, two rows by two columns by default. Each node serves one device port. The port carries a frame of 32 time slots, one slot per clock. Inside a row, every device sample is broadcast to the speech store of every node in that row. The time-slot interchange for a connection is done only by the node that sits in the source's row and in the destination's column. That node puts the result on a vertical link down its column. The destination node then picks, slot by slot, which vertical link to forward.

A single host write port programs two kinds of table entry. The first is a per-node control-store entry that names a source column and a source slot. The second is a per-node selector entry that names a source row. Each write goes into a shadow copy. The shadow copy is copied into the working tables at the next frame boundary, so a frame is never switched with a mix of old and new settings. The whole fabric exists twice, as plane A and plane B. Both planes are fed the same device samples and the same programming, so they produce the same output.

Top module: `tsw_fabric`

## Requirements
- R1: `slot_idx` is 0 after reset. It rises by one every clock and returns to 0 after SLOTS-1. The sample a device drives while `slot_idx` equals s belongs to slot s.
- R2: After reset and until a connection has been programmed and a frame boundary has passed, every output sample of both planes is the idle octet 0xD5.
- R3: A connection between two nodes of the same row carries the source sample to the destination node. The selector names the node's own row and the control store is read locally.
- R4: A connection between rows crosses a vertical link. This covers both the same-column and the diagonal cases. The interchange is done by the node in the source row and the destination column.
- R5: The delay is fixed at one frame. A sample that enters at slot s of frame n leaves at output slot t of frame n+1, for any pair s and t (t may be less than, equal to, or greater than s). The output for slot t is registered at the edge at which `slot_idx` equals t.
- R6: An output slot sends 0xD5 when its selector entry is invalid or when the addressed control-store entry is invalid. Writing an entry with `cfg_valid`=0 removes the connection.
- R7: A write changes only the shadow tables. These are copied to the working tables at the edge at which `slot_idx` equals SLOTS-1. A write made in that same cycle therefore takes effect one frame later.
- R8: One source sample can be sent to several output slots on different nodes in the same frame (multicast).
- R9: A wideband group of up to 31 consecutive source slots, mapped to consecutive output slots, leaves in the same relative order and from the same input frame.
- R10: Plane A and plane B produce identical outputs in every cycle.
- R11: Any full assignment of a source (any node, any slot) to every output slot of every node can be programmed at the same time, with no conflict between entries (strictly non-blocking).
- R12: Write encoding. `cfg_tgt`=0 writes the control store of node (`cfg_node_row`,`cfg_node_col`) at index (`cfg_dst_row`,`cfg_slot`) with {`cfg_valid`, source column `cfg_src_sel`, source slot `cfg_src_slot`}. `cfg_tgt`=1 writes that node's selector at `cfg_slot` with {`cfg_valid`, source row `cfg_src_sel`}. Device port n = r*COLS+c occupies `dev_in`/`dev_out_*` bits [n*W +: W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| dev_in | input | ROWS*COLS*W | Device samples, port n at [n*W +: W] |
| cfg_we | input | 1 | Table write strobe |
| cfg_tgt | input | 1 | 0 control store, 1 selector |
| cfg_node_row | input | RW | Row of the addressed node |
| cfg_node_col | input | CW | Column of the addressed node |
| cfg_dst_row | input | RW | Destination row index (control store only) |
| cfg_slot | input | SW | Output slot index |
| cfg_valid | input | 1 | Entry valid bit |
| cfg_src_sel | input | XW | Source column (control store) or source row (selector) |
| cfg_src_slot | input | SW | Source slot (control store only) |
| slot_idx | output | SW | Current slot counter |
| dev_out_a | output | ROWS*COLS*W | Plane A output samples |
| dev_out_b | output | ROWS*COLS*W | Plane B output samples |

## Verification
The bench builds the fabric with its defaults: 2 rows, 2 columns, 32 slots and 8-bit samples. With these values every connection class is reachable: local same-row, same-column vertical, and diagonal. The frame is also short, so dozens of frame boundaries fit in a run, including writes that land on the final slot. Thirty-two slots leave room for a 6-channel wideband bundle. They also make a full random permutation of all 128 output slots cheap to program, which exercises non-blocking operation and reprogramming while traffic is flowing.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    localparam logic [7:0] IDLE_OCTET = 8'hD5;

    typedef enum logic {
        TGT_CSTORE = 1'b0,
        TGT_SELECT = 1'b1
    } cfg_tgt_e;

    function automatic int idx_w(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tsf_frame_timer.sv
module tsf_frame_timer #(
    parameter int SLOTS = 32,
    localparam int SW = tsf_pkg::idx_w(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] slot,
    output logic          bank,
    output logic          frame_end
);

    assign frame_end = (slot == SW'(SLOTS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
            bank <= 1'b0;
        end else if (frame_end) begin
            slot <= '0;
            bank <= ~bank;
        end else begin
            slot <= slot + SW'(1);
        end
    end

    // R1: the counter wraps to zero after the last slot
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (slot == '0));

    // R1: inside a frame the counter advances by one
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> (slot == $past(slot) + SW'(1)));

    // R5: the write bank flips at every frame boundary
    a_r5_bank_flip: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (bank != $past(bank)));

    // R5: the write bank is held inside a frame
    a_r5_bank_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(bank));

endmodule

// File: rtl/tsf_switch_node.sv
module tsf_switch_node #(
    parameter int ROWS   = 2,
    parameter int COLS   = 2,
    parameter int SLOTS  = 32,
    parameter int W      = 8,
    parameter int MY_ROW = 0,
    parameter int MY_COL = 0,
    localparam int SW = tsf_pkg::idx_w(SLOTS),
    localparam int RW = tsf_pkg::idx_w(ROWS),
    localparam int CW = tsf_pkg::idx_w(COLS),
    localparam int XW = tsf_pkg::max2(RW, CW)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [SW-1:0]             slot,
    input  logic                      wbank,
    input  logic                      frame_end,
    input  logic [COLS-1:0][W-1:0]    row_in,
    input  logic [ROWS-1:0][W-1:0]    vert_in,
    output logic [ROWS-1:0][W-1:0]    vert_out,
    input  logic                      cfg_we,
    input  logic                      cfg_tgt,
    input  logic [RW-1:0]             cfg_node_row,
    input  logic [CW-1:0]             cfg_node_col,
    input  logic [RW-1:0]             cfg_dst_row,
    input  logic [SW-1:0]             cfg_slot,
    input  logic                      cfg_valid,
    input  logic [XW-1:0]             cfg_src_sel,
    input  logic [SW-1:0]             cfg_src_slot,
    output logic [W-1:0]              dout
);

    localparam logic [W-1:0] IDLE = W'(tsf_pkg::IDLE_OCTET);

    typedef struct packed {
        logic          v;
        logic [CW-1:0] col;
        logic [SW-1:0] slot;
    } cs_ent_t;

    typedef struct packed {
        logic          v;
        logic [RW-1:0] row;
    } sel_ent_t;

    cs_ent_t  [ROWS-1:0][SLOTS-1:0] cs_sh;
    cs_ent_t  [ROWS-1:0][SLOTS-1:0] cs_act;
    sel_ent_t [SLOTS-1:0]           sel_sh;
    sel_ent_t [SLOTS-1:0]           sel_act;

    // speech store: two frame banks, one sample per row member and slot
    logic [W-1:0] ss [2][COLS][SLOTS];

    logic rbank;
    logic hit;
    logic idx_ok;

    assign rbank  = ~wbank;
    assign hit    = cfg_we && (cfg_node_row == RW'(MY_ROW)) && (cfg_node_col == CW'(MY_COL));
    assign idx_ok = (int'(cfg_slot) < SLOTS) && (int'(cfg_dst_row) < ROWS);

    // horizontal broadcast: every row member's sample lands here
    always_ff @(posedge clk) begin
        for (int c = 0; c < COLS; c++) begin
            ss[wbank][c][slot] <= row_in[c];
        end
    end

    // shadow tables and frame-boundary transfer
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_sh   <= '0;
            cs_act  <= '0;
            sel_sh  <= '0;
            sel_act <= '0;
        end else begin
            if (frame_end) begin
                cs_act  <= cs_sh;
                sel_act <= sel_sh;
            end
            if (hit && idx_ok) begin
                if (cfg_tgt == tsf_pkg::TGT_SELECT) begin
                    sel_sh[cfg_slot] <= '{v: cfg_valid, row: cfg_src_sel[RW-1:0]};
                end else begin
                    cs_sh[cfg_dst_row][cfg_slot] <= '{v: cfg_valid, col: cfg_src_sel[CW-1:0],
                                                      slot: cfg_src_slot};
                end
            end
        end
    end

    // time stage: one read port per destination row
    for (genvar d = 0; d < ROWS; d++) begin : g_vout
        cs_ent_t ent;
        assign ent         = cs_act[d][slot];
        assign vert_out[d] = ent.v ? ss[rbank][ent.col][ent.slot] : IDLE;
    end

    // space stage: choose the vertical from the source row
    sel_ent_t pick;
    assign pick = sel_act[slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= IDLE;
        end else begin
            dout <= pick.v ? vert_in[pick.row] : IDLE;
        end
    end

    // R7: working tables change only at a frame boundary
    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> ($stable(cs_act) && $stable(sel_act)));

endmodule

// File: rtl/tsf_plane.sv
module tsf_plane #(
    parameter int ROWS  = 2,
    parameter int COLS  = 2,
    parameter int SLOTS = 32,
    parameter int W     = 8,
    localparam int N  = ROWS * COLS,
    localparam int SW = tsf_pkg::idx_w(SLOTS),
    localparam int RW = tsf_pkg::idx_w(ROWS),
    localparam int CW = tsf_pkg::idx_w(COLS),
    localparam int XW = tsf_pkg::max2(RW, CW)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SW-1:0]   slot,
    input  logic            wbank,
    input  logic            frame_end,
    input  logic [N*W-1:0]  din,
    input  logic            cfg_we,
    input  logic            cfg_tgt,
    input  logic [RW-1:0]   cfg_node_row,
    input  logic [CW-1:0]   cfg_node_col,
    input  logic [RW-1:0]   cfg_dst_row,
    input  logic [SW-1:0]   cfg_slot,
    input  logic            cfg_valid,
    input  logic [XW-1:0]   cfg_src_sel,
    input  logic [SW-1:0]   cfg_src_slot,
    output logic [N*W-1:0]  dout
);

    logic [ROWS-1:0][COLS-1:0][W-1:0]           rowbus;
    logic [ROWS-1:0][COLS-1:0][W-1:0]           douts;
    // vlink[source row][column][destination row]
    logic [ROWS-1:0][COLS-1:0][ROWS-1:0][W-1:0] vlink;
    // vin[destination row][column][source row]
    logic [ROWS-1:0][COLS-1:0][ROWS-1:0][W-1:0] vin;

    assign rowbus = din;
    assign dout   = douts;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            for (genvar s = 0; s < ROWS; s++) begin : g_vert
                assign vin[r][c][s] = vlink[s][c][r];
            end

            tsf_switch_node #(
                .ROWS(ROWS), .COLS(COLS), .SLOTS(SLOTS), .W(W),
                .MY_ROW(r), .MY_COL(c)
            ) i_node (
                .clk          (clk),
                .rst          (rst),
                .slot         (slot),
                .wbank        (wbank),
                .frame_end    (frame_end),
                .row_in       (rowbus[r]),
                .vert_in      (vin[r][c]),
                .vert_out     (vlink[r][c]),
                .cfg_we       (cfg_we),
                .cfg_tgt      (cfg_tgt),
                .cfg_node_row (cfg_node_row),
                .cfg_node_col (cfg_node_col),
                .cfg_dst_row  (cfg_dst_row),
                .cfg_slot     (cfg_slot),
                .cfg_valid    (cfg_valid),
                .cfg_src_sel  (cfg_src_sel),
                .cfg_src_slot (cfg_src_slot),
                .dout         (douts[r][c])
            );
        end
    end

endmodule

// File: rtl/tsw_fabric.sv
module tsw_fabric #(
    parameter int ROWS  = 2,
    parameter int COLS  = 2,
    parameter int SLOTS = 32,
    parameter int W     = 8,
    localparam int N  = ROWS * COLS,
    localparam int SW = tsf_pkg::idx_w(SLOTS),
    localparam int RW = tsf_pkg::idx_w(ROWS),
    localparam int CW = tsf_pkg::idx_w(COLS),
    localparam int XW = tsf_pkg::max2(RW, CW)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N*W-1:0]  dev_in,
    input  logic            cfg_we,
    input  logic            cfg_tgt,
    input  logic [RW-1:0]   cfg_node_row,
    input  logic [CW-1:0]   cfg_node_col,
    input  logic [RW-1:0]   cfg_dst_row,
    input  logic [SW-1:0]   cfg_slot,
    input  logic            cfg_valid,
    input  logic [XW-1:0]   cfg_src_sel,
    input  logic [SW-1:0]   cfg_src_slot,
    output logic [SW-1:0]   slot_idx,
    output logic [N*W-1:0]  dev_out_a,
    output logic [N*W-1:0]  dev_out_b
);

    localparam int PLANES = 2;

    logic                          wbank;
    logic                          frame_end;
    logic [PLANES-1:0][N*W-1:0]    plane_out;

    tsf_frame_timer #(.SLOTS(SLOTS)) i_timer (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot_idx),
        .bank      (wbank),
        .frame_end (frame_end)
    );

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        tsf_plane #(.ROWS(ROWS), .COLS(COLS), .SLOTS(SLOTS), .W(W)) i_plane (
            .clk          (clk),
            .rst          (rst),
            .slot         (slot_idx),
            .wbank        (wbank),
            .frame_end    (frame_end),
            .din          (dev_in),
            .cfg_we       (cfg_we),
            .cfg_tgt      (cfg_tgt),
            .cfg_node_row (cfg_node_row),
            .cfg_node_col (cfg_node_col),
            .cfg_dst_row  (cfg_dst_row),
            .cfg_slot     (cfg_slot),
            .cfg_valid    (cfg_valid),
            .cfg_src_sel  (cfg_src_sel),
            .cfg_src_slot (cfg_src_slot),
            .dout         (plane_out[p])
        );
    end

    assign dev_out_a = plane_out[0];
    assign dev_out_b = plane_out[1];

    // R10: the duplicated planes never diverge
    a_r10_planes_agree: assert property (@(posedge clk) disable iff (rst)
        dev_out_a == dev_out_b);

endmodule

// File: tb/test_tsw_fabric.sv
`timescale 1ns/100ps
module test_tsw_fabric;

    localparam int ROWS  = 2;
    localparam int COLS  = 2;
    localparam int SLOTS = 32;
    localparam int W     = 8;
    localparam int N     = ROWS * COLS;
    localparam int SW    = 5;
    localparam int RW    = 1;
    localparam int CW    = 1;
    localparam int XW    = 1;
    localparam int IDLE  = 'hD5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N*W-1:0]  dev_in = '0;
    logic            cfg_we = 1'b0;
    logic            cfg_tgt = 1'b0;
    logic [RW-1:0]   cfg_node_row = '0;
    logic [CW-1:0]   cfg_node_col = '0;
    logic [RW-1:0]   cfg_dst_row = '0;
    logic [SW-1:0]   cfg_slot = '0;
    logic            cfg_valid = 1'b0;
    logic [XW-1:0]   cfg_src_sel = '0;
    logic [SW-1:0]   cfg_src_slot = '0;
    logic [SW-1:0]   slot_idx;
    logic [N*W-1:0]  dev_out_a;
    logic [N*W-1:0]  dev_out_b;

    tsw_fabric #(.ROWS(ROWS), .COLS(COLS), .SLOTS(SLOTS), .W(W)) i_tsw_fabric (
        .clk(clk), .rst(rst), .dev_in(dev_in),
        .cfg_we(cfg_we), .cfg_tgt(cfg_tgt), .cfg_node_row(cfg_node_row),
        .cfg_node_col(cfg_node_col), .cfg_dst_row(cfg_dst_row), .cfg_slot(cfg_slot),
        .cfg_valid(cfg_valid), .cfg_src_sel(cfg_src_sel), .cfg_src_slot(cfg_src_slot),
        .slot_idx(slot_idx), .dev_out_a(dev_out_a), .dev_out_b(dev_out_b)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_req = "R2";

    // reference connection map (shadow and working), mirrors R7 and R12
    int cs_v_sh  [N][ROWS][SLOTS];
    int cs_c_sh  [N][ROWS][SLOTS];
    int cs_s_sh  [N][ROWS][SLOTS];
    int cs_v_act [N][ROWS][SLOTS];
    int cs_c_act [N][ROWS][SLOTS];
    int cs_s_act [N][ROWS][SLOTS];
    int sel_v_sh [N][SLOTS];
    int sel_r_sh [N][SLOTS];
    int sel_v_act[N][SLOTS];
    int sel_r_act[N][SLOTS];
    int cur_in   [N][SLOTS];
    int prev_in  [N][SLOTS];
    int m_cnt = 0;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (slot %0d)", req, act, exp, m_cnt);
        end
    endtask

    function automatic int expect_out(input int n, input int t);
        int d, c, sr, s;
        d = n / COLS;
        c = n % COLS;
        if (sel_v_act[n][t] == 0) return IDLE;
        sr = sel_r_act[n][t];
        s  = sr * COLS + c;
        if (cs_v_act[s][d][t] == 0) return IDLE;
        return prev_in[sr * COLS + cs_c_act[s][d][t]][cs_s_act[s][d][t]];
    endfunction

    task automatic step();
        int v;
        for (int n = 0; n < N; n++) begin
            v = int'($urandom() & 32'hFF);
            dev_in[n*W +: W] = W'(v);
            cur_in[n][m_cnt] = v;
        end
        @(posedge clk);
        @(negedge clk);
        for (int n = 0; n < N; n++) begin
            check(cur_req, int'(dev_out_a[n*W +: W]), expect_out(n, m_cnt));
            check("R10", int'(dev_out_b[n*W +: W]), int'(dev_out_a[n*W +: W]));
        end
        if (m_cnt == SLOTS - 1) begin
            cs_v_act = cs_v_sh; cs_c_act = cs_c_sh; cs_s_act = cs_s_sh;
            sel_v_act = sel_v_sh; sel_r_act = sel_r_sh;
            prev_in = cur_in;
            m_cnt = 0;
        end else begin
            m_cnt++;
        end
        if (cfg_we) begin
            if (cfg_tgt == 1'b0) begin
                v = int'(cfg_node_row) * COLS + int'(cfg_node_col);
                cs_v_sh[v][cfg_dst_row][cfg_slot] = int'(cfg_valid);
                cs_c_sh[v][cfg_dst_row][cfg_slot] = int'(cfg_src_sel);
                cs_s_sh[v][cfg_dst_row][cfg_slot] = int'(cfg_src_slot);
            end else begin
                v = int'(cfg_node_row) * COLS + int'(cfg_node_col);
                sel_v_sh[v][cfg_slot] = int'(cfg_valid);
                sel_r_sh[v][cfg_slot] = int'(cfg_src_sel);
            end
            cfg_we = 1'b0;
        end
        check("R1", int'(slot_idx), m_cnt);
    endtask

    task automatic run(input int cycles);
        for (int i = 0; i < cycles; i++) step();
    endtask

    task automatic wait_slot(input int k);
        while (m_cnt != k) step();
    endtask

    // source (sr,sc,ss) to destination (dr,dc,t): control store, then selector
    task automatic connect(input int sr, input int sc, input int ss,
                           input int dr, input int dc, input int t, input int valid);
        cfg_we = 1'b1; cfg_tgt = 1'b0;
        cfg_node_row = RW'(sr); cfg_node_col = CW'(dc); cfg_dst_row = RW'(dr);
        cfg_slot = SW'(t); cfg_valid = valid[0]; cfg_src_sel = XW'(sc); cfg_src_slot = SW'(ss);
        step();
        cfg_we = 1'b1; cfg_tgt = 1'b1;
        cfg_node_row = RW'(dr); cfg_node_col = CW'(dc);
        cfg_slot = SW'(t); cfg_valid = valid[0]; cfg_src_sel = XW'(sr);
        step();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R2: reset state of every output and R1 counter origin
        for (int n = 0; n < N; n++) begin
            check("R2", int'(dev_out_a[n*W +: W]), IDLE);
            check("R2", int'(dev_out_b[n*W +: W]), IDLE);
        end
        check("R1", int'(slot_idx), 0);

        cur_req = "R2";
        run(2 * SLOTS);

        // R3 same row, R4 same column and diagonal, R5 slot pairs below and above
        cur_req = "R3";
        connect(0, 0, 3, 0, 1, 7, 1);
        cur_req = "R4";
        connect(0, 1, 10, 1, 1, 2, 1);
        connect(1, 0, 31, 0, 1, 0, 1);
        cur_req = "R5";
        connect(1, 1, 0, 1, 1, 31, 1);
        // R8 multicast of one source to two nodes
        cur_req = "R8";
        connect(0, 0, 5, 1, 0, 5, 1);
        connect(0, 0, 5, 1, 1, 6, 1);
        // R9 wideband bundle of six channels kept in order
        cur_req = "R9";
        for (int k = 0; k < 6; k++) connect(1, 1, 4 + k, 0, 0, 20 + k, 1);
        run(3 * SLOTS);

        // R6 remove a connection: output returns to idle
        cur_req = "R6";
        connect(0, 0, 3, 0, 1, 7, 0);
        run(2 * SLOTS);

        // R7 writes around the boundary: selector written in the last slot lags a frame
        cur_req = "R7";
        wait_slot(SLOTS - 2);
        connect(1, 0, 12, 0, 0, 9, 1);
        run(3 * SLOTS);

        // R11 full random permutations, reprogrammed while traffic runs
        cur_req = "R11";
        for (int round = 0; round < 4; round++) begin
            for (int n = 0; n < N; n++) begin
                for (int t = 0; t < SLOTS; t++) begin
                    int src;
                    src = int'($urandom_range(N - 1, 0));
                    connect(src / COLS, src % COLS, int'($urandom_range(SLOTS - 1, 0)),
                            n / COLS, n % COLS, t, 1);
                end
            end
            run(2 * SLOTS);
        end
        finish_run();
    end

endmodule